// File: doc/BRIEF.md
# Dual-Context Block Cipher DMA Sequencer

This block sits in front of a single 128-bit block-cipher engine and feeds it from system memory on behalf of two software-programmed jobs, context A and context B. Each context holds a source pointer, a destination pointer, a byte count and a control word. The control word picks the key source, the direction (encrypt or decrypt), whether blocks are chained, and two memory coherency flags. Setting a context's start bit queues that job. The sequencer then fetches 16-byte blocks one at a time, runs each block through the engine, and stores each result at the destination. When the job ends it raises that context's completion flag.

Only one engine exists, so only one job runs at a time. A second job can be armed while the first is still running and begins as soon as the first has finished. In chained mode both contexts use the same 128-bit initial vector. The sequencer keeps its own running copy of the chain value, taken from the vector when a job begins. Each completion flag can be polled, or it can be unmasked so that it drives the interrupt line.

Registers are written through a word-addressed port (`reg_addr_i`, 4 bits). Context A occupies words 0 to 3 and context B words 4 to 7, each as {source, destination, length, control}. Words 8 to 11 hold the vector, least significant word first. Word 12 is the start command, word 13 clears completion flags, and word 14 is the interrupt mask. In a control word, bit 0 selects the key, bit 1 selects decryption, bit 2 enables chaining and bits 4:3 carry the coherency flags. In words 12, 13 and 14, bit 0 refers to context A and bit 1 to context B.

Top module: `cipher_dma_seq`

## Requirements
- R1: The four low bits of every written source, destination and length value are stored as zero, so every memory address is a multiple of 16 and the length counts whole 16-byte blocks.
- R2: A started context reads length/16 blocks from source+16k and writes each result to destination+16k, in increasing order of k. A memory request stays asserted, with a stable address, until `mem_ack_i`.
- R3: In unchained mode the engine input is the block as read and the stored result is the engine output. The engine sees the context's key select (control bit 0) and direction (control bit 1), and each engine start is a single-cycle pulse.
- R4: Only one block is in the engine at a time. A context started while the other is running issues no memory request until the running job has set its completion flag.
- R5: When both start bits are set in the same write, context A runs first.
- R6: A length below 16 completes at once: the completion flag sets and there is no memory request.
- R7: Chained encryption feeds the engine with the plaintext XOR the previous ciphertext block, using the vector for the first block.
- R8: Chained decryption stores the engine output XOR the previous ciphertext block, using the vector for the first block, so it inverts R7 with the same vector and key.
- R9: Each context's completion flag is cleared only by writing 1 to its bit in word 13. `irq_o` is the OR of the completion flags whose mask bit in word 14 is 1.
- R10: Throughout a context's memory requests, `mem_coh_o` carries that context's control bits 4:3.
- R11: After reset there is no memory request and no engine start, and both completion flags and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| done_o | output | 2 | Completion flags, bit 0 context A, bit 1 context B |
| irq_o | output | 1 | Interrupt, OR of unmasked completion flags |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the block |
| mem_wdata_o | output | 128 | Write data |
| mem_coh_o | output | 2 | Coherency flags of the active context |
| mem_ack_i | input | 1 | Request done; read data is valid in the same cycle |
| mem_rdata_i | input | 128 | Read data |
| eng_start_o | output | 1 | Engine start pulse |
| eng_key_sel_o | output | 1 | Key source for the engine |
| eng_decrypt_o | output | 1 | Direction for the engine, 1 means decrypt |
| eng_data_o | output | 128 | Engine input block |
| eng_done_i | input | 1 | Engine result valid |
| eng_data_i | input | 128 | Engine output block |

## Verification
The bench builds the block with its default parameters: 32-bit addresses and lengths, 128-bit data and 16-byte blocks. With these values the low-bit masking and the whole-block counting run on the widths the block is meant for. The bench's memory model answers after two wait cycles and its engine model after four. Because a job therefore takes many cycles, a second start can land while the first job is still in flight, which makes the queueing, same-write arbitration and chain-register hand-off reachable. The engine model is invertible and depends on the key, so a wrong key, direction or chaining order shows up in the stored data.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FIN, S_RD, S_EGO, S_EWAIT, S_WR
  } seq_state_e;

  typedef struct packed {
    logic [1:0] coh;
    logic       cbc;
    logic       dec;
    logic       key_sel;
  } ctx_ctrl_t;

  localparam int unsigned NCTX     = 2;
  localparam int unsigned WA_CTX_B = 4;
  localparam int unsigned WA_IV    = 8;
  localparam int unsigned WA_CMD   = 12;
  localparam int unsigned WA_CLR   = 13;
  localparam int unsigned WA_MASK  = 14;
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 32,
  parameter int unsigned DW        = 128,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [3:0]      addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            pick_i,
  input  logic            pick_ctx_i,
  input  logic            fin_i,
  input  logic            fin_ctx_i,
  output logic [AW-1:0]   src_o  [NCTX],
  output logic [AW-1:0]   dst_o  [NCTX],
  output logic [LW-1:0]   len_o  [NCTX],
  output ctx_ctrl_t       ctrl_o [NCTX],
  output logic [DW-1:0]   iv_o,
  output logic [NCTX-1:0] pend_o,
  output logic [NCTX-1:0] done_o,
  output logic            irq_o
);
  localparam int unsigned OFS   = $clog2(BLK_BYTES);
  localparam int unsigned IV_WN = DW / 32;
  localparam int unsigned CW    = $bits(ctx_ctrl_t);

  logic [NCTX-1:0] mask_q;

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    localparam logic [3:0] BASE = 4'(c * WA_CTX_B);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_o[c]  <= '0;
        dst_o[c]  <= '0;
        len_o[c]  <= '0;
        ctrl_o[c] <= '0;
        pend_o[c] <= 1'b0;
        done_o[c] <= 1'b0;
      end else begin
        if (we_i && addr_i == BASE)      src_o[c]  <= {wdata_i[AW-1:OFS], OFS'(0)};
        if (we_i && addr_i == BASE + 1)  dst_o[c]  <= {wdata_i[AW-1:OFS], OFS'(0)};
        if (we_i && addr_i == BASE + 2)  len_o[c]  <= {wdata_i[LW-1:OFS], OFS'(0)};
        if (we_i && addr_i == BASE + 3)  ctrl_o[c] <= wdata_i[CW-1:0];
        pend_o[c] <= (pend_o[c] && !(pick_i && pick_ctx_i == c[0]))
                   || (we_i && addr_i == 4'(WA_CMD) && wdata_i[c]);
        // a finishing job wins over a same-cycle clear
        done_o[c] <= (done_o[c] && !(we_i && addr_i == 4'(WA_CLR) && wdata_i[c]))
                   || (fin_i && fin_ctx_i == c[0]);
      end
    end
  end

  for (genvar w = 0; w < IV_WN; w++) begin : g_iv
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) iv_o[w*32 +: 32] <= '0;
      else if (we_i && addr_i == 4'(WA_IV + w)) iv_o[w*32 +: 32] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else if (we_i && addr_i == 4'(WA_MASK)) mask_q <= wdata_i[NCTX-1:0];
  end

  assign irq_o = |(done_o & mask_q);
endmodule

// File: rtl/cdma_fsm.sv
module cdma_fsm
  import cdma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 32,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCTX-1:0] pend_i,
  input  logic [AW-1:0]   src_i [NCTX],
  input  logic [AW-1:0]   dst_i [NCTX],
  input  logic [LW-1:0]   len_i [NCTX],
  input  logic            mem_ack_i,
  input  logic            eng_done_i,
  output logic            ctx_o,
  output logic            pick_o,
  output logic            pick_ctx_o,
  output logic            fin_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic            rd_cap_o,
  output logic            eng_start_o,
  output logic            eng_cap_o
);
  localparam int unsigned OFS = $clog2(BLK_BYTES);
  localparam int unsigned CNT = LW - OFS;

  seq_state_e     state_q;
  logic [AW-1:0]  src_q, dst_q;
  logic [CNT-1:0] rem_q, rem_n;

  assign pick_o     = (state_q == S_IDLE) && |pend_i;
  assign pick_ctx_o = ~pend_i[0];  // A first
  assign rem_n      = len_i[pick_ctx_o][LW-1:OFS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ctx_o   <= 1'b0;
      src_q   <= '0;
      dst_q   <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (pick_o) begin
          ctx_o   <= pick_ctx_o;
          src_q   <= src_i[pick_ctx_o];
          dst_q   <= dst_i[pick_ctx_o];
          rem_q   <= rem_n;
          state_q <= (rem_n == '0) ? S_FIN : S_RD;
        end
        S_FIN: state_q <= S_IDLE;
        S_RD: if (mem_ack_i) begin
          src_q   <= src_q + AW'(BLK_BYTES);
          state_q <= S_EGO;
        end
        S_EGO:   state_q <= S_EWAIT;
        S_EWAIT: if (eng_done_i) state_q <= S_WR;
        S_WR: if (mem_ack_i) begin
          dst_q   <= dst_q + AW'(BLK_BYTES);
          rem_q   <= rem_q - 1'b1;
          state_q <= (rem_q == CNT'(1)) ? S_FIN : S_RD;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign fin_o       = (state_q == S_FIN);
  assign mem_req_o   = (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_addr_o  = mem_we_o ? dst_q : src_q;
  assign rd_cap_o    = (state_q == S_RD) && mem_ack_i;
  assign eng_start_o = (state_q == S_EGO);
  assign eng_cap_o   = (state_q == S_EWAIT) && eng_done_i;
endmodule

// File: rtl/cdma_chain.sv
module cdma_chain #(
  parameter int unsigned DW = 128
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] iv_i,
  input  logic          load_i,
  input  logic          cbc_i,
  input  logic          dec_i,
  input  logic          rd_cap_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          eng_cap_i,
  input  logic [DW-1:0] eng_res_i,
  output logic [DW-1:0] eng_in_o,
  output logic [DW-1:0] wdata_o
);
  logic [DW-1:0] chain_q, blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      blk_q   <= '0;
      wdata_o <= '0;
    end else begin
      if (load_i)   chain_q <= iv_i;
      if (rd_cap_i) blk_q   <= rdata_i;
      if (eng_cap_i) begin
        wdata_o <= (cbc_i && dec_i) ? (eng_res_i ^ chain_q) : eng_res_i;
        // chain always follows the ciphertext side
        if (cbc_i) chain_q <= dec_i ? blk_q : eng_res_i;
      end
    end
  end

  assign eng_in_o = (cbc_i && !dec_i) ? (blk_q ^ chain_q) : blk_q;
endmodule

// File: rtl/cipher_dma_seq.sv
module cipher_dma_seq
  import cdma_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned LW        = 32,
  parameter int unsigned DW        = 128,
  parameter int unsigned BLK_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [1:0]    done_o,
  output logic          irq_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic [1:0]    mem_coh_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          eng_start_o,
  output logic          eng_key_sel_o,
  output logic          eng_decrypt_o,
  output logic [DW-1:0] eng_data_o,
  input  logic          eng_done_i,
  input  logic [DW-1:0] eng_data_i
);
  logic [AW-1:0]   src_w  [NCTX];
  logic [AW-1:0]   dst_w  [NCTX];
  logic [LW-1:0]   len_w  [NCTX];
  ctx_ctrl_t       ctrl_w [NCTX];
  ctx_ctrl_t       act_ctrl;
  logic [DW-1:0]   iv_w;
  logic [NCTX-1:0] pend_w;
  logic ctx_w, pick_w, pick_ctx_w, fin_w, rd_cap_w, eng_cap_w;

  cdma_regs #(.AW(AW), .LW(LW), .DW(DW), .BLK_BYTES(BLK_BYTES)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .pick_i(pick_w), .pick_ctx_i(pick_ctx_w),
    .fin_i(fin_w), .fin_ctx_i(ctx_w),
    .src_o(src_w), .dst_o(dst_w), .len_o(len_w), .ctrl_o(ctrl_w),
    .iv_o(iv_w), .pend_o(pend_w), .done_o(done_o), .irq_o(irq_o)
  );

  cdma_fsm #(.AW(AW), .LW(LW), .BLK_BYTES(BLK_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .pend_i(pend_w), .src_i(src_w), .dst_i(dst_w), .len_i(len_w),
    .mem_ack_i, .eng_done_i,
    .ctx_o(ctx_w), .pick_o(pick_w), .pick_ctx_o(pick_ctx_w), .fin_o(fin_w),
    .mem_req_o, .mem_we_o, .mem_addr_o,
    .rd_cap_o(rd_cap_w), .eng_start_o, .eng_cap_o(eng_cap_w)
  );

  assign act_ctrl = ctrl_w[ctx_w];

  cdma_chain #(.DW(DW)) u_chain (
    .clk_i, .rst_ni,
    .iv_i(iv_w), .load_i(pick_w),
    .cbc_i(act_ctrl.cbc), .dec_i(act_ctrl.dec),
    .rd_cap_i(rd_cap_w), .rdata_i(mem_rdata_i),
    .eng_cap_i(eng_cap_w), .eng_res_i(eng_data_i),
    .eng_in_o(eng_data_o), .wdata_o(mem_wdata_o)
  );

  assign mem_coh_o     = act_ctrl.coh;
  assign eng_key_sel_o = act_ctrl.key_sel;
  assign eng_decrypt_o = act_ctrl.dec;
endmodule

// File: rtl/cipher_dma_seq_chk.sv
module cipher_dma_seq_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [3:0]    reg_addr_i,
  input logic [31:0]   reg_wdata_i,
  input logic [1:0]    done_o,
  input logic          irq_o,
  input logic          mem_req_o,
  input logic          mem_ack_i,
  input logic [AW-1:0] mem_addr_o,
  input logic          eng_start_o,
  input logic          eng_done_i
);
  logic eng_busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          eng_busy_q <= 1'b0;
    else if (eng_start_o) eng_busy_q <= 1'b1;
    else if (eng_done_i)  eng_busy_q <= 1'b0;
  end

  p_addr_align_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[3:0] == 4'h0);

  p_req_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

  p_start_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);

  p_one_engine_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (!eng_busy_q && !mem_req_o));

  p_irq_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o == 2'b00) |-> !irq_o);

  p_clr_a_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o[0]) |-> $past(reg_we_i && reg_addr_i == 4'd13 && reg_wdata_i[0]));

  p_clr_b_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o[1]) |-> $past(reg_we_i && reg_addr_i == 4'd13 && reg_wdata_i[1]));
endmodule

bind cipher_dma_seq cipher_dma_seq_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
  .done_o(done_o), .irq_o(irq_o),
  .mem_req_o(mem_req_o), .mem_ack_i(mem_ack_i), .mem_addr_o(mem_addr_o),
  .eng_start_o(eng_start_o), .eng_done_i(eng_done_i)
);

// File: tb/cipher_dma_seq_bench.sv
`timescale 1ns/1ps
module cipher_dma_seq_bench;
  localparam int MEM_LAT = 2;
  localparam int ENG_LAT = 4;
  localparam logic [127:0] KEY0 = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
  localparam logic [127:0] KEY1 = 128'h13579bdf2468ace0fedcba9876543210;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic         reg_we_i = 1'b0;
  logic [3:0]   reg_addr_i = '0;
  logic [31:0]  reg_wdata_i = '0;
  logic [1:0]   done_o, mem_coh_o;
  logic         irq_o, mem_req_o, mem_we_o, eng_start_o, eng_key_sel_o, eng_decrypt_o;
  logic [31:0]  mem_addr_o;
  logic [127:0] mem_wdata_o, eng_data_o;
  logic         mem_ack_i = 1'b0, eng_done_i = 1'b0;
  logic [127:0] mem_rdata_i = '0, eng_data_i = '0;

  cipher_dma_seq u_cipher_dma_seq (.*);

  int n_chk = 0, n_bad = 0;

  function automatic logic [127:0] pat(input int idx);
    logic [31:0] w = 32'h9e3779b9 * (idx + 1);
    return {w, ~w, w ^ 32'h5a5a5a5a, w + idx};
  endfunction

  function automatic logic [127:0] eng_f(input logic [127:0] d, input logic k, input logic dec);
    logic [127:0] key = k ? KEY1 : KEY0;
    logic [127:0] t;
    if (!dec) begin t = d ^ key; return {t[119:0], t[127:120]}; end
    t = {d[7:0], d[127:8]};
    return t ^ key;
  endfunction

  // memory model
  logic [127:0] mem [256];
  logic         mem_vld [256];
  int mcnt = 0, rd_cnt = 0, wr_cnt = 0;
  logic [31:0] rd_addr_log [64];
  logic [1:0]  rd_done_log [64];
  logic [1:0]  rd_coh_log  [64];

  function automatic logic [127:0] memrd(input logic [31:0] a);
    return mem_vld[a[11:4]] ? mem[a[11:4]] : pat(int'(a[11:4]));
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mem_ack_i <= 1'b0; mcnt <= 0;
      for (int i = 0; i < 256; i++) mem_vld[i] <= 1'b0;
    end else if (mem_ack_i) begin
      mem_ack_i <= 1'b0;
    end else if (mem_req_o) begin
      if (mcnt == MEM_LAT) begin
        mem_ack_i <= 1'b1; mcnt <= 0;
        if (mem_we_o) begin
          mem[mem_addr_o[11:4]] <= mem_wdata_o;
          mem_vld[mem_addr_o[11:4]] <= 1'b1;
          wr_cnt <= wr_cnt + 1;
        end else begin
          mem_rdata_i <= memrd(mem_addr_o);
          rd_addr_log[rd_cnt % 64] <= mem_addr_o;
          rd_done_log[rd_cnt % 64] <= done_o;
          rd_coh_log[rd_cnt % 64]  <= mem_coh_o;
          rd_cnt <= rd_cnt + 1;
        end
      end else mcnt <= mcnt + 1;
    end
  end

  // engine model
  int ecnt = 0;
  logic [127:0] e_in; logic e_k, e_d;
  always @(posedge clk_i) begin
    eng_done_i <= 1'b0;
    if (eng_start_o) begin
      ecnt <= 1; e_in <= eng_data_o; e_k <= eng_key_sel_o; e_d <= eng_decrypt_o;
    end else if (ecnt == ENG_LAT) begin
      ecnt <= 0; eng_done_i <= 1'b1; eng_data_i <= eng_f(e_in, e_k, e_d);
    end else if (ecnt != 0) ecnt <= ecnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d,
                      input logic [31:0] l, input logic [31:0] ctl);
    reg_wr(4'(c*4), s); reg_wr(4'(c*4+1), d); reg_wr(4'(c*4+2), l); reg_wr(4'(c*4+3), ctl);
  endtask

  task automatic wait_done(input int c);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      if (done_o[c]) return;
    end
    chk(1'b0, "R2 job did not finish", 128'(done_o), 128'(c));
  endtask

  task automatic t_reset();
    chk(!mem_req_o && !eng_start_o, "R11 idle outputs", 128'({mem_req_o, eng_start_o}), 0);
    chk(done_o == 2'b00 && !irq_o, "R11 flags clear", 128'({done_o, irq_o}), 0);
  endtask

  task automatic t_ecb_enc();
    int r0 = rd_cnt;
    prog(0, 32'h107, 32'h40f, 32'h3f, 32'h0);
    reg_wr(12, 1);
    wait_done(0);
    chk(rd_cnt - r0 == 3, "R1 length rounded to 3 blocks", 128'(rd_cnt - r0), 3);
    for (int k = 0; k < 3; k++) begin
      chk(rd_addr_log[r0+k] == 32'h100 + 16*k, "R2 read address", 128'(rd_addr_log[r0+k]), 128'(32'h100 + 16*k));
      chk(memrd(32'h400 + 16*k) == eng_f(pat(16 + k), 0, 0), "R3 ECB encrypt result",
          memrd(32'h400 + 16*k), eng_f(pat(16 + k), 0, 0));
    end
    chk(done_o == 2'b01 && !irq_o, "R9 masked flag", 128'({done_o, irq_o}), 128'(3'b010));
    reg_wr(14, 1);
    chk(irq_o, "R9 unmasked irq", 128'(irq_o), 1);
    reg_wr(13, 1);
    chk(done_o == 2'b00 && !irq_o, "R9 write-one clear", 128'({done_o, irq_o}), 0);
    reg_wr(14, 0);
  endtask

  task automatic t_ecb_dec_b();
    int r0 = rd_cnt;
    prog(1, 32'h200, 32'h500, 32'h20, 32'h13);
    reg_wr(12, 2);
    wait_done(1);
    for (int k = 0; k < 2; k++) begin
      chk(memrd(32'h500 + 16*k) == eng_f(pat(32 + k), 1, 1), "R3 key1 decrypt result",
          memrd(32'h500 + 16*k), eng_f(pat(32 + k), 1, 1));
      chk(rd_coh_log[r0+k] == 2'b10, "R10 coherency flags", 128'(rd_coh_log[r0+k]), 2);
    end
    reg_wr(13, 2);
  endtask

  task automatic t_cbc();
    logic [127:0] iv = 128'hdeadbeef_0badf00d_cafef00d_12345678;
    logic [127:0] c = iv;
    for (int w = 0; w < 4; w++) reg_wr(4'(8 + w), iv[w*32 +: 32]);
    prog(0, 32'h100, 32'h600, 32'h30, 32'h4);
    reg_wr(12, 1);
    wait_done(0);
    for (int k = 0; k < 3; k++) begin
      c = eng_f(pat(16 + k) ^ c, 0, 0);
      chk(memrd(32'h600 + 16*k) == c, "R7 chained encrypt", memrd(32'h600 + 16*k), c);
    end
    prog(1, 32'h600, 32'h700, 32'h30, 32'h6);
    reg_wr(12, 2);
    wait_done(1);
    for (int k = 0; k < 3; k++)
      chk(memrd(32'h700 + 16*k) == pat(16 + k), "R8 chained decrypt", memrd(32'h700 + 16*k), pat(16 + k));
    reg_wr(13, 3);
  endtask

  task automatic t_same_cycle();
    int r0 = rd_cnt;
    prog(0, 32'h200, 32'h800, 32'h20, 32'h0);
    prog(1, 32'h300, 32'h900, 32'h20, 32'h0);
    reg_wr(12, 3);
    wait_done(1);
    chk(done_o == 2'b11, "R5 both finished", 128'(done_o), 3);
    chk(rd_addr_log[r0] == 32'h200 && rd_addr_log[r0+1] == 32'h210, "R5 A served first",
        128'(rd_addr_log[r0]), 128'(32'h200));
    chk(rd_addr_log[r0+2] == 32'h300, "R5 B after A", 128'(rd_addr_log[r0+2]), 128'(32'h300));
    reg_wr(13, 3);
  endtask

  task automatic t_queued();
    int r0 = rd_cnt;
    prog(0, 32'h100, 32'ha00, 32'h40, 32'h0);
    prog(1, 32'h300, 32'hb00, 32'h10, 32'h0);
    reg_wr(12, 1);
    repeat (3) @(negedge clk_i);
    reg_wr(12, 2);
    wait_done(1);
    chk(rd_cnt - r0 == 5, "R4 read count", 128'(rd_cnt - r0), 5);
    chk(rd_addr_log[r0+4] == 32'h300 && rd_done_log[r0+4][0], "R4 B waits for A",
        128'({rd_addr_log[r0+4], rd_done_log[r0+4]}), 128'({32'h300, 2'b01}));
    chk(memrd(32'hb00) == eng_f(pat(48), 0, 0), "R4 B result", memrd(32'hb00), eng_f(pat(48), 0, 0));
    reg_wr(13, 3);
  endtask

  task automatic t_zero_len();
    int r0 = rd_cnt, w0 = wr_cnt;
    prog(0, 32'h100, 32'hc00, 32'h0f, 32'h0);
    reg_wr(12, 1);
    repeat (4) @(negedge clk_i);
    chk(done_o[0], "R6 zero length completes", 128'(done_o), 1);
    chk(rd_cnt == r0 && wr_cnt == w0, "R6 no memory traffic", 128'(rd_cnt - r0 + wr_cnt - w0), 0);
    reg_wr(13, 1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ecb_enc();
    t_ecb_dec_b();
    t_cbc();
    t_same_cycle();
    t_queued();
    t_zero_len();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end
endmodule